// File: doc/BRIEF.md
# Host-Side Data FIFO with Half-Depth Watermarks

This block is the word buffer between a host register or bus port and the data path of an SD/MMC card interface. One direction input selects its role. In transmit mode the host writes 32-bit words and the card side drains them. In receive mode the card side fills it and the host reads it out. The oldest stored word is always presented on a single head output, with no read latency.

Status flags tell the host or a DMA engine how much work it may do in one go. Half-empty is raised when at least half of the slots are free, and half-full when at least half of them hold data. Empty, full and data-available complete the set. A down-counter is loaded with the transfer length, converted to whole words, and counts the words that still have to pass the host side. A DMA burst request is raised when one burst of half the depth fits and is still owed. One-cycle error pulses report a card word that arrives while the buffer is full and a card word that is requested while the buffer is empty. Dropping the enable flushes the buffer. The card-side serialiser and CRC logic sit outside this block.

Top module: `sdx_data_fifo`

## Requirements
- R1: After reset, with `path_en` high, the block shows `fl_empty`=1, `fl_half_empty`=1, `fl_half_full`=0, `fl_full`=0, `fl_avail`=0 and `words_left`=0.
- R2: With L words stored and depth D, `fl_half_empty` is 1 exactly when D-L >= D/2. `fl_half_full` is 1 exactly when L >= D/2. A full buffer therefore shows half-full and not half-empty.
- R3: `fl_empty` is 1 when L=0, `fl_full` is 1 when L=D, and `fl_avail` is 1 when L>=1. An empty buffer also shows half-empty.
- R4: Words leave in the order they entered, and `fifo_head` shows the oldest one. `dir_rx`=0 is transmit: `host_wr` writes and `card_pop` removes. `dir_rx`=1 is receive: `card_push` writes and `host_rd` removes. The strobes of the inactive direction have no effect.
- R5: A write while full and a remove while empty are ignored, and the stored contents do not change.
- R6: A `len_load` pulse sets `words_left` to ceil(`len_bytes`/4), so a partial last word is padded to a whole word. Each word accepted on the host side (a transmit write or a receive read) lowers it by one, and it stops at 0. A load in the same cycle as an accepted word wins.
- R7: `dma_req` is 1 when `path_en` is high, the mode watermark is set (half-empty in transmit, half-full in receive) and `words_left` >= D/2.
- R8: `card_push` in receive mode while full gives a one-cycle `overrun` pulse in the next cycle, and the word is dropped. `card_pop` in transmit mode while empty gives a one-cycle `underrun` pulse in the next cycle.
- R9: While `path_en` is low, all five flags and `dma_req` are 0. At the next edge the stored words are discarded and `words_left` is cleared, so on re-enable the buffer reads empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_en | input | 1 | Data path enable; low flushes the buffer |
| dir_rx | input | 1 | 0 = transmit, 1 = receive |
| len_load | input | 1 | Load the transfer length |
| len_bytes | input | LEN_W | Transfer length in bytes |
| host_wr | input | 1 | Host word write (transmit) |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host word read (receive) |
| card_push | input | 1 | Card delivers a word (receive) |
| card_wdata | input | DATA_W | Card delivered data |
| card_pop | input | 1 | Card takes a word (transmit) |
| fifo_head | output | DATA_W | Oldest stored word |
| fl_empty | output | 1 | No words stored |
| fl_half_empty | output | 1 | At least half the slots free |
| fl_half_full | output | 1 | At least half the slots used |
| fl_full | output | 1 | All slots used |
| fl_avail | output | 1 | At least one word stored |
| words_left | output | LEN_W-1 | Words still to move on the host side |
| dma_req | output | 1 | Burst of half the depth requested |
| overrun | output | 1 | Receive overrun pulse |
| underrun | output | 1 | Transmit underrun pulse |

## Verification
The bound checker evaluates these properties on every cycle:
- A full buffer never shows half-empty.
- An enabled empty buffer shows half-empty and neither data-available nor full.
- Each illegal card-side access is followed by its error pulse.
- A full transmit buffer with no card pop stays full.
- Every accepted host word lowers the counter by exactly one.
- A re-enabled buffer reads empty.

Other behaviour needs the bench's scenarios:
- Word ordering and dropped data, both in transmit and in receive.
- The exact fill level at which each watermark changes.
- The rounding of partial words by the length load.
- The DMA request edges at the words-left boundary.
- The counter stopping at zero.

// File: rtl/sdx_fifo_pkg.sv
package sdx_fifo_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic empty;
      logic half_empty;
      logic half_full;
      logic full;
      logic avail;
   } fifo_flags_t;

endpackage

// File: rtl/sdx_fifo_store.sv
module sdx_fifo_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  level
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   // pointer wrap: free-running for power-of-two depths, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_nxt;
         if (rd_en) rd_ptr <= rd_nxt;
         case ({wr_en, rd_en})
            2'b10:   level <= level + CNT_W'(1);
            2'b01:   level <= level - CNT_W'(1);
            default: level <= level;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/sdx_fifo_flags.sv
module sdx_fifo_flags
   import sdx_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int HALF  = DEPTH / 2
) (
   input  logic        enable,
   input  logic [CNT_W-1:0] level,
   output fifo_flags_t flags
);

   fifo_flags_t raw;

   always_comb begin
      raw.empty      = (level == '0);
      raw.full       = (level == CNT_W'(DEPTH));
      raw.avail      = (level != '0);
      raw.half_full  = (level >= CNT_W'(HALF));
      raw.half_empty = (level <= CNT_W'(DEPTH - HALF));
      flags          = enable ? raw : '0;
   end

endmodule

// File: rtl/sdx_xfer_count.sv
module sdx_xfer_count #(
   parameter int LEN_W = 16,
   localparam int LEFT_W = LEN_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              load,
   input  logic [LEN_W-1:0]  len_bytes,
   input  logic              step,
   output logic [LEFT_W-1:0] words_left
);

   logic [LEN_W:0] padded;

   // round the byte count up to whole 32-bit words
   assign padded = {1'b0, len_bytes} + (LEN_W + 1)'(3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words_left <= '0;
      end else if (flush) begin
         words_left <= '0;
      end else if (load) begin
         words_left <= padded[LEN_W:2];
      end else if (step && (words_left != '0)) begin
         words_left <= words_left - LEFT_W'(1);
      end
   end

endmodule

// File: rtl/sdx_data_fifo.sv
module sdx_data_fifo
   import sdx_fifo_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int LEN_W  = 16,
   localparam int HALF   = DEPTH / 2,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int LEFT_W = LEN_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              path_en,
   input  logic              dir_rx,
   input  logic              len_load,
   input  logic [LEN_W-1:0]  len_bytes,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   input  logic              card_push,
   input  logic [DATA_W-1:0] card_wdata,
   input  logic              card_pop,
   output logic [DATA_W-1:0] fifo_head,
   output logic              fl_empty,
   output logic              fl_half_empty,
   output logic              fl_half_full,
   output logic              fl_full,
   output logic              fl_avail,
   output logic [LEFT_W-1:0] words_left,
   output logic              dma_req,
   output logic              overrun,
   output logic              underrun
);

   // elaboration-time parameter checks
   generate
      if (DEPTH < 4 || (DEPTH % 2) != 0) begin : g_bad_depth
         $error("sdx_data_fifo: DEPTH must be even and at least 4");
      end
      if (LEN_W < 4 || LEN_W > 32) begin : g_bad_len
         $error("sdx_data_fifo: LEN_W must lie in 4..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("sdx_data_fifo: DATA_W must be positive");
      end
   endgenerate

   xfer_dir_e   dir;
   fifo_flags_t flg;
   logic [CNT_W-1:0]  level;
   logic [DATA_W-1:0] wr_data;
   logic host_wr_ok, host_rd_ok, card_push_ok, card_pop_ok;
   logic wr_en, rd_en, flush, wm_hit, enough_left;
   logic overrun_q, underrun_q;

   assign dir   = xfer_dir_e'(dir_rx);
   assign flush = !path_en;

   always_comb begin
      host_wr_ok   = path_en && (dir == DIR_TX) && host_wr   && !flg.full;
      card_pop_ok  = path_en && (dir == DIR_TX) && card_pop  && !flg.empty;
      card_push_ok = path_en && (dir == DIR_RX) && card_push && !flg.full;
      host_rd_ok   = path_en && (dir == DIR_RX) && host_rd   && !flg.empty;
      wr_en        = host_wr_ok  || card_push_ok;
      rd_en        = card_pop_ok || host_rd_ok;
      wr_data      = (dir == DIR_RX) ? card_wdata : host_wdata;
   end

   sdx_fifo_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (fifo_head),
      .level   (level)
   );

   sdx_fifo_flags #(
      .DEPTH (DEPTH)
   ) u_flags (
      .enable (path_en),
      .level  (level),
      .flags  (flg)
   );

   sdx_xfer_count #(
      .LEN_W (LEN_W)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .load       (len_load),
      .len_bytes  (len_bytes),
      .step       (host_wr_ok || host_rd_ok),
      .words_left (words_left)
   );

   // burst request: one half-depth burst fits and is still owed
   assign wm_hit      = (dir == DIR_RX) ? flg.half_full : flg.half_empty;
   assign enough_left = (32'(words_left) >= 32'(HALF));
   assign dma_req     = path_en && wm_hit && enough_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun_q  <= 1'b0;
         underrun_q <= 1'b0;
      end else begin
         overrun_q  <= path_en && (dir == DIR_RX) && card_push && flg.full;
         underrun_q <= path_en && (dir == DIR_TX) && card_pop  && flg.empty;
      end
   end

   assign overrun       = overrun_q;
   assign underrun      = underrun_q;
   assign fl_empty      = flg.empty;
   assign fl_half_empty = flg.half_empty;
   assign fl_half_full  = flg.half_full;
   assign fl_full       = flg.full;
   assign fl_avail      = flg.avail;

endmodule

// File: rtl/sdx_data_fifo_chk.sv
module sdx_data_fifo_chk #(
   parameter int DEPTH = 16,
   parameter int LEN_W = 16,
   localparam int HALF   = DEPTH / 2,
   localparam int LEFT_W = LEN_W - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              path_en,
   input logic              dir_rx,
   input logic              len_load,
   input logic              host_wr,
   input logic              card_push,
   input logic              card_pop,
   input logic              fl_empty,
   input logic              fl_half_empty,
   input logic              fl_half_full,
   input logic              fl_full,
   input logic              fl_avail,
   input logic [LEFT_W-1:0] words_left,
   input logic              dma_req,
   input logic              overrun,
   input logic              underrun
);

   a_r2_full_not_half_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fl_full |-> (fl_half_full && !fl_half_empty));

   a_r3_empty_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && fl_empty) |-> (fl_half_empty && !fl_avail && !fl_full));

   a_r8_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && dir_rx && card_push && fl_full) |=> overrun);

   a_r8_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && !dir_rx && card_pop && fl_empty) |=> underrun);

   a_r5_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && !dir_rx && fl_full && !card_pop) |=> (fl_full || !path_en));

   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && !dir_rx && host_wr && !fl_full && !len_load && (words_left != '0))
      |=> (words_left == $past(words_left) - LEFT_W'(1)));

   a_r9_reenable_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && !$past(path_en)) |-> fl_empty);

   a_r7_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (path_en && (32'(words_left) >= 32'(HALF))
                   && (dir_rx ? fl_half_full : fl_half_empty)));

endmodule

bind sdx_data_fifo sdx_data_fifo_chk #(
   .DEPTH (DEPTH),
   .LEN_W (LEN_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .path_en       (path_en),
   .dir_rx        (dir_rx),
   .len_load      (len_load),
   .host_wr       (host_wr),
   .card_push     (card_push),
   .card_pop      (card_pop),
   .fl_empty      (fl_empty),
   .fl_half_empty (fl_half_empty),
   .fl_half_full  (fl_half_full),
   .fl_full       (fl_full),
   .fl_avail      (fl_avail),
   .words_left    (words_left),
   .dma_req       (dma_req),
   .overrun       (overrun),
   .underrun      (underrun)
);

// File: tb/sdx_data_fifo_tb.sv
`timescale 1ns/1ps
module sdx_data_fifo_tb;

   localparam int DATA_W = 32;
   localparam int DEPTH  = 16;
   localparam int LEN_W  = 16;
   localparam int HALF   = DEPTH / 2;

   logic clk = 1'b0;
   logic rst_n, path_en, dir_rx, len_load, host_wr, host_rd, card_push, card_pop;
   logic [LEN_W-1:0]  len_bytes;
   logic [DATA_W-1:0] host_wdata, card_wdata, fifo_head;
   logic fl_empty, fl_half_empty, fl_half_full, fl_full, fl_avail;
   logic [LEN_W-2:0] words_left;
   logic dma_req, overrun, underrun;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   sdx_data_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .path_en(path_en), .dir_rx(dir_rx),
      .len_load(len_load), .len_bytes(len_bytes),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
      .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
      .fifo_head(fifo_head), .fl_empty(fl_empty), .fl_half_empty(fl_half_empty),
      .fl_half_full(fl_half_full), .fl_full(fl_full), .fl_avail(fl_avail),
      .words_left(words_left), .dma_req(dma_req),
      .overrun(overrun), .underrun(underrun)
   );

   // flag vector {empty, half_empty, half_full, full, avail}
   function automatic logic [4:0] flagv();
      return {fl_empty, fl_half_empty, fl_half_full, fl_full, fl_avail};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   typedef struct packed {
      logic       ld;
      logic       hw;
      logic       cp;
      logic [7:0] len;
      logic [7:0] dat;
      logic [4:0] flg;
      logic [7:0] wl;
      logic       dma;
   } vec_t;

   // transmit-mode table: one row per cycle, expected state after that edge
   localparam vec_t VEC [7] = '{
      '{1'b1, 1'b0, 1'b0, 8'd37, 8'h00, 5'b11000, 8'd10, 1'b1},
      '{1'b0, 1'b1, 1'b0, 8'd0,  8'hA1, 5'b01001, 8'd9,  1'b1},
      '{1'b0, 1'b1, 1'b0, 8'd0,  8'hA2, 5'b01001, 8'd8,  1'b1},
      '{1'b0, 1'b1, 1'b0, 8'd0,  8'hA3, 5'b01001, 8'd7,  1'b0},
      '{1'b0, 1'b1, 1'b1, 8'd0,  8'hA4, 5'b01001, 8'd6,  1'b0},
      '{1'b0, 1'b0, 1'b1, 8'd0,  8'h00, 5'b01001, 8'd6,  1'b0},
      '{1'b1, 1'b0, 1'b0, 8'd64, 8'h00, 5'b01001, 8'd16, 1'b1}
   };

   initial begin
      #(8ns * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst_n = 1'b0; path_en = 1'b1; dir_rx = 1'b0; len_load = 1'b0; len_bytes = '0;
      host_wr = 1'b0; host_rd = 1'b0; card_push = 1'b0; card_pop = 1'b0;
      host_wdata = '0; card_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 flags", 32'(flagv()), 32'b11000);
      chk("R1 words_left", 32'(words_left), 0);

      // table walk, transmit mode (R2 R3 R6 R7)
      foreach (VEC[i]) begin
         len_load   = VEC[i].ld;
         len_bytes  = LEN_W'(VEC[i].len);
         host_wr    = VEC[i].hw;
         card_pop   = VEC[i].cp;
         host_wdata = {24'hC0DE00, VEC[i].dat};
         tick();
         len_load = 1'b0; host_wr = 1'b0; card_pop = 1'b0;
         chk($sformatf("R3 table flags row %0d", i), 32'(flagv()), 32'(VEC[i].flg));
         chk($sformatf("R6 table words_left row %0d", i), 32'(words_left), 32'(VEC[i].wl));
         chk($sformatf("R7 table dma row %0d", i), 32'(dma_req), 32'(VEC[i].dma));
      end

      // R9 flush
      path_en = 1'b0;
      tick();
      chk("R9 flags while disabled", 32'(flagv()), 0);
      chk("R9 words_left cleared", 32'(words_left), 0);
      chk("R9 dma low", 32'(dma_req), 0);
      path_en = 1'b1;
      tick();
      chk("R9 empty on re-enable", 32'(flagv()), 32'b11000);

      // R2 watermarks across a transmit fill
      for (int i = 1; i <= DEPTH; i++) begin
         host_wr = 1'b1;
         host_wdata = 32'hF00D0000 + 32'(i);
         tick();
         host_wr = 1'b0;
         chk($sformatf("R2 half_empty at level %0d", i), 32'(fl_half_empty), 32'((DEPTH - i) >= HALF));
         chk($sformatf("R2 half_full at level %0d", i), 32'(fl_half_full), 32'(i >= HALF));
         chk($sformatf("R3 full at level %0d", i), 32'(fl_full), 32'(i == DEPTH));
      end

      // R5 write while full ignored
      host_wr = 1'b1; host_wdata = 32'hDEADBEEF;
      tick();
      host_wr = 1'b0;
      chk("R5 still full", 32'(fl_full), 1);
      chk("R5 head unchanged", fifo_head, 32'hF00D0001);

      // R4 transmit order
      for (int i = 1; i <= DEPTH; i++) begin
         chk($sformatf("R4 tx order word %0d", i), fifo_head, 32'hF00D0000 + 32'(i));
         card_pop = 1'b1;
         tick();
         card_pop = 1'b0;
      end
      chk("R3 empty after drain", 32'(flagv()), 32'b11000);

      // R8 underrun pulse
      card_pop = 1'b1;
      tick();
      card_pop = 1'b0;
      chk("R8 underrun pulse", 32'(underrun), 1);
      tick();
      chk("R8 underrun single cycle", 32'(underrun), 0);

      // R4 card push in transmit mode ignored
      card_push = 1'b1; card_wdata = 32'h12345678;
      tick();
      card_push = 1'b0;
      chk("R4 card_push ignored in tx", 32'(fl_empty), 1);

      // receive mode
      dir_rx = 1'b1;
      len_load = 1'b1; len_bytes = 16'd64;
      tick();
      len_load = 1'b0;
      chk("R6 load 64 bytes", 32'(words_left), 16);
      for (int i = 1; i <= DEPTH; i++) begin
         card_push = 1'b1;
         card_wdata = 32'hBEEF0000 + 32'(i);
         tick();
         card_push = 1'b0;
         if (i == HALF - 1) chk("R7 rx dma below half", 32'(dma_req), 0);
         if (i == HALF)     chk("R7 rx dma at half", 32'(dma_req), 1);
      end
      chk("R3 rx full", 32'(fl_full), 1);
      card_push = 1'b1; card_wdata = 32'hBADBAD00;
      tick();
      card_push = 1'b0;
      chk("R8 overrun pulse", 32'(overrun), 1);
      chk("R8 full kept", 32'(fl_full), 1);

      host_wr = 1'b1; host_wdata = 32'h55555555;
      tick();
      host_wr = 1'b0;
      chk("R4 host_wr ignored in rx", 32'(words_left), 16);
      chk("R8 overrun single cycle", 32'(overrun), 0);

      for (int i = 1; i <= DEPTH; i++) begin
         chk($sformatf("R4 rx order word %0d", i), fifo_head, 32'hBEEF0000 + 32'(i));
         host_rd = 1'b1;
         tick();
         host_rd = 1'b0;
      end
      chk("R6 words_left after reads", 32'(words_left), 0);
      chk("R8 overrun word dropped", 32'(fl_empty), 1);
      host_rd = 1'b1;
      tick();
      host_rd = 1'b0;
      chk("R5 read while empty ignored", 32'(flagv()), 32'b11000);
      chk("R6 counter stops at zero", 32'(words_left), 0);

      // R6 padding
      len_load = 1'b1; len_bytes = 16'd5;
      tick();
      chk("R6 pad 5 bytes", 32'(words_left), 2);
      len_bytes = 16'd1;
      tick();
      len_load = 1'b0;
      chk("R6 pad 1 byte", 32'(words_left), 1);

      summary();
   end

endmodule